// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Selectable Deselect Latency

This block is a small synchronous static memory with a registered read path. Every control, address and data input is sampled on the rising clock edge into an input stage. A read captured on one edge shows its word on the data output after the following edge. The 72-bit word is split into eight lanes of 9 bits each. Writes can update any subset of lanes through per-lane strobes gated by a byte-write enable. A global write updates the whole word regardless of those controls.

The data-output enable depends on three things: an asynchronous output enable, the pipelined read-valid flag, and a not-deselected term. A run-time mode input sets how quickly a deselect removes drive. In single-cycle mode, drive drops as soon as the deselect sits in the input stage, which is one stage ahead of read data. In dual-cycle mode, the deselect travels the same pipeline depth as a read. Drive therefore stays on for the full cycle after the deselect is captured and drops after the second edge.

A host uses it as a tightly coupled buffer. The host issues one command per cycle and turns the shared data bus around with the output enable and the deselect mode.

Top module: `sync_sram_pipe`

## Requirements
- R1: While reset is asserted, and after reset until a read completes, `rdata_oe` is 0, whatever the value of `oe`.
- R2: A read is a cycle with `cs_en`=1, `gwe`=0 and not (`bwe`=1 with any `lane_we` bit set). It is sampled on edge N. The stored word appears on `rdata` after edge N+1, and `rdata_oe` rises there when `oe`=1 and drive is not cut by R8.
- R3: With `cs_en`=1, `gwe`=0 and `bwe`=1, lane i (bits 9i+8 down to 9i) is written from `wdata` only when `lane_we[i]`=1. The other lanes keep their contents.
- R4: With `cs_en`=1 and `gwe`=1, all 72 bits are written, whatever the values of `bwe` and `lane_we`.
- R5: With `cs_en`=1, `gwe`=0, `bwe`=1 and `lane_we`=0, the cycle is a read and nothing is written.
- R6: With `cs_en`=0, nothing is written, whatever the write controls.
- R7: A read issued in the cycle immediately after a write to the same address returns the newly written word.
- R8: When `dual_mode`=0 (single-cycle), `rdata_oe` is 0 in the cycle after an edge that captured `cs_en`=0, even if read data from the previous command is in the output stage.
- R9: When `dual_mode`=1 (dual-cycle), a read followed by a deselect keeps `rdata_oe`=1 for the cycle after the deselect is captured. Drive drops after the next edge.
- R10: `oe` acts on `rdata_oe` combinationally, without waiting for a clock edge. `rdata_oe` is never 1 while `oe` is 0.
- R11: `rdata` holds its value through any cycle whose output-stage update did not come from a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_en | input | 1 | Chip select, active high, sampled |
| addr | input | ADDR_W (8) | Word address, sampled |
| wdata | input | LANES*LANE_W (72) | Write data, sampled |
| lane_we | input | LANES (8) | Per-lane write strobes, active high |
| bwe | input | 1 | Byte-write enable qualifying `lane_we` |
| gwe | input | 1 | Global write of every lane |
| oe | input | 1 | Asynchronous output enable, active high |
| dual_mode | input | 1 | 0 = single-cycle deselect, 1 = dual-cycle deselect |
| rdata | output | LANES*LANE_W (72) | Registered read data |
| rdata_oe | output | 1 | Data-driver enable |

## Verification
The checker watches the output-enable rules on every cycle. It confirms that drive never appears without `oe` or without a read two edges earlier. It confirms that single-cycle mode cuts drive the cycle after a deselect capture, and that dual-cycle mode holds drive for that cycle. It also confirms that `rdata` is frozen whenever no read entered the output stage. The contents of the array can only be shown by the bench's scenarios. These are lane merges from byte writes, global writes overriding the strobes, strobe-less byte writes acting as reads, writes blocked by a deselect, and read-after-write returning fresh data. The scenarios also cover the direct single-versus-dual comparison and the asynchronous `oe` response between edges.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  typedef enum logic {
    DSEL_SINGLE = 1'b0,
    DSEL_DUAL   = 1'b1
  } dsel_e;
endpackage

// File: rtl/sram_in_stage.sv
// Input capture stage: control always sampled, address/data loaded only when selected.
module sram_in_stage #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_we,
  input  logic              bwe,
  input  logic              gwe,
  output logic              cs_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] wdata_q,
  output logic [LANES-1:0]  lane_q,
  output logic              bwe_q,
  output logic              gwe_q
);
  logic [ADDR_W-1:0] addr_d;
  logic [WORD_W-1:0] wdata_d;
  logic              bwe_d, gwe_d;
  logic [LANES-1:0]  lane_d;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (cs_en) begin
      addr_d  = addr;
      wdata_d = wdata;
    end
    bwe_d  = cs_en & bwe;
    gwe_d  = cs_en & gwe;
    lane_d = cs_en ? lane_we : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      bwe_q  <= 1'b0;
      gwe_q  <= 1'b0;
      lane_q <= '0;
    end else begin
      cs_q   <= cs_en;
      bwe_q  <= bwe_d;
      gwe_q  <= gwe_d;
      lane_q <= lane_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr_d;
    wdata_q <= wdata_d;
  end
endmodule

// File: rtl/sram_wr_decode.sv
// Turns the captured command into a per-lane write mask and a read strobe.
module sram_wr_decode #(
  parameter int LANES = 8
) (
  input  logic             cs_q,
  input  logic             gwe_q,
  input  logic             bwe_q,
  input  logic [LANES-1:0] lane_q,
  output logic [LANES-1:0] wr_mask,
  output logic             rd_cmd
);
  logic any_lane;

  assign any_lane = |lane_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane_en
    assign wr_mask[i] = cs_q & (gwe_q | (bwe_q & lane_q[i]));
  end

  assign rd_cmd = cs_q & ~gwe_q & ~(bwe_q & any_lane);
endmodule

// File: rtl/sram_lane_array.sv
// Storage sliced into independent lanes, each with its own write enable.
module sram_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [WORD_W-1:0] wdata_q,
  output logic [WORD_W-1:0] rd_word
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[i]) begin
        mem[addr_q] <= wdata_q[i*LANE_W +: LANE_W];
      end
    end

    assign rd_word[i*LANE_W +: LANE_W] = mem[addr_q];
  end
endmodule

// File: rtl/sram_out_stage.sv
// Output register plus the driver-enable with selectable deselect depth.
module sram_out_stage
  import sram_pipe_pkg::*;
#(
  parameter int WORD_W = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              cs_q,
  input  logic              oe,
  input  logic              dual_mode,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] dout_q, dout_d;
  logic              keep_on;

  always_comb begin
    vld_d  = rd_cmd;
    dout_d = dout_q;
    if (rd_cmd) begin
      dout_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    dout_q <= dout_d;
  end

  // Dual mode: deselect cuts drive only via vld_q (same depth as a read).
  // Single mode: the captured deselect in the input stage cuts drive at once.
  assign keep_on  = (dsel_e'(dual_mode) == DSEL_DUAL) ? 1'b1 : cs_q;
  assign rdata_oe = oe & vld_q & keep_on;
  assign rdata    = dout_q;
endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_we,
  input  logic              bwe,
  input  logic              gwe,
  input  logic              oe,
  input  logic              dual_mode,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);
  logic              rst_meta, rst_core;
  logic              cs_q, bwe_q, gwe_q, rd_cmd;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, rd_word;
  logic [LANES-1:0]  lane_q, wr_mask;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  sram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk(clk), .rst_n(rst_core), .cs_en(cs_en), .addr(addr), .wdata(wdata),
    .lane_we(lane_we), .bwe(bwe), .gwe(gwe), .cs_q(cs_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .lane_q(lane_q), .bwe_q(bwe_q), .gwe_q(gwe_q)
  );

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .cs_q(cs_q), .gwe_q(gwe_q), .bwe_q(bwe_q), .lane_q(lane_q),
    .wr_mask(wr_mask), .rd_cmd(rd_cmd)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .wr_mask(wr_mask), .addr_q(addr_q), .wdata_q(wdata_q),
    .rd_word(rd_word)
  );

  sram_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_core), .rd_cmd(rd_cmd), .rd_word(rd_word),
    .cs_q(cs_q), .oe(oe), .dual_mode(dual_mode), .rdata(rdata),
    .rdata_oe(rdata_oe)
  );
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk #(
  parameter int LANES  = 8,
  parameter int WORD_W = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_en,
  input logic [LANES-1:0]  lane_we,
  input logic              bwe,
  input logic              gwe,
  input logic              oe,
  input logic              dual_mode,
  input logic [WORD_W-1:0] rdata,
  input logic              rdata_oe
);
  logic [2:0] settle_q;
  logic       settled;
  logic       rd_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= 3'd0;
    end else if (settle_q != 3'd5) begin
      settle_q <= settle_q + 3'd1;
    end
  end

  assign settled = (settle_q == 3'd5);
  assign rd_now  = cs_en & ~gwe & ~(bwe & (|lane_we));

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> oe); // R10
  AST_SINGLE_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && !$past(cs_en)) |-> !rdata_oe); // R8
  AST_SINGLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !dual_mode && oe && $past(cs_en) && $past(rd_now, 2)) |-> rdata_oe); // R8
  AST_DUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && dual_mode && oe && $past(rd_now, 2)) |-> rdata_oe); // R9
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && rdata_oe) |-> $past(rd_now, 2)); // R2
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !$past(rd_now, 2)) |-> $stable(rdata)); // R11
endmodule

bind sync_sram_pipe sram_pipe_chk #(.LANES(LANES), .WORD_W(LANES * LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .lane_we(lane_we), .bwe(bwe),
  .gwe(gwe), .oe(oe), .dual_mode(dual_mode), .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/tb_sync_sram_pipe.sv
module tb_sync_sram_pipe;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int LANES  = 8;
  localparam int LANE_W = 9;
  localparam int W      = LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_en, bwe, gwe, oe, dual_mode;
  logic [ADDR_W-1:0] addr;
  logic [W-1:0]      wdata;
  logic [LANES-1:0]  lane_we;
  logic [W-1:0]      rdata;
  logic              rdata_oe;
  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  sync_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .addr(addr), .wdata(wdata),
    .lane_we(lane_we), .bwe(bwe), .gwe(gwe), .oe(oe), .dual_mode(dual_mode),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [W-1:0] pat(input int a, input int salt);
    logic [W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*LANE_W +: LANE_W] = LANE_W'(a*7 + i*37 + salt);
    return v;
  endfunction

  task automatic chk_w(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rdata actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_b(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rdata_oe actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one command at a negedge, let it be captured, return at the next negedge.
  task automatic step(input logic c, input int a, input logic [W-1:0] d,
                      input logic [LANES-1:0] l, input logic b, input logic g);
    cs_en = c; addr = ADDR_W'(a); wdata = d; lane_we = l; bwe = b; gwe = g;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_all(input int a, input logic [W-1:0] d);
    step(1'b1, a, d, '0, 1'b0, 1'b1);
  endtask

  task automatic idle();
    step(1'b0, 0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic read_word(input int a, output logic [W-1:0] v);
    step(1'b1, a, '0, '0, 1'b0, 1'b0);
    step(1'b1, a, '0, '0, 1'b0, 1'b0);
    v = rdata;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; oe = 1'b1; dual_mode = 1'b1;
    cs_en = 1'b0; addr = '0; wdata = '0; lane_we = '0; bwe = 1'b0; gwe = 1'b0;
    repeat (3) @(negedge clk);
    chk_b("R1 in reset", rdata_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_b("R1 after reset", rdata_oe, 1'b0);
  endtask

  task automatic t_global_and_read();
    logic [W-1:0] v;
    for (int a = 0; a < 4; a++) wr_all(a * 50 + 3, pat(a * 50 + 3, 1));
    idle();
    for (int a = 0; a < 4; a++) begin
      read_word(a * 50 + 3, v);
      chk_w("R2 read data", v, pat(a * 50 + 3, 1));
      chk_b("R2 drive on", rdata_oe, 1'b1);
    end
    // R4: gwe overrides bwe/strobes even with bwe=1 and strobes empty
    step(1'b1, 20, pat(20, 9), '0, 1'b1, 1'b1);
    idle();
    read_word(20, v);
    chk_w("R4 global write", v, pat(20, 9));
  endtask

  task automatic t_byte_write();
    logic [W-1:0] v, exp;
    logic [LANES-1:0] m = 8'b1010_0101;
    wr_all(30, pat(30, 2));
    step(1'b1, 30, pat(30, 77), m, 1'b1, 1'b0);
    idle();
    for (int i = 0; i < LANES; i++)
      exp[i*LANE_W +: LANE_W] = m[i] ? pat(30, 77)[i*LANE_W +: LANE_W]
                                     : pat(30, 2)[i*LANE_W +: LANE_W];
    read_word(30, v);
    chk_w("R3 lane merge", v, exp);
    // strobes without bwe: a read, no write
    step(1'b1, 30, pat(1, 1), 8'hFF, 1'b0, 1'b0);
    idle();
    read_word(30, v);
    chk_w("R3 strobes need bwe", v, exp);
  endtask

  task automatic t_no_strobe();
    logic [W-1:0] v;
    wr_all(40, pat(40, 3));
    idle();
    step(1'b1, 40, pat(40, 99), '0, 1'b1, 1'b0);
    step(1'b1, 40, '0, '0, 1'b0, 1'b0);
    chk_w("R5 bwe no strobe reads", rdata, pat(40, 3));
    chk_b("R5 drive on", rdata_oe, 1'b1);
    read_word(40, v);
    chk_w("R5 no write", v, pat(40, 3));
  endtask

  task automatic t_deselect_write();
    logic [W-1:0] v;
    wr_all(50, pat(50, 4));
    step(1'b0, 50, pat(50, 55), 8'hFF, 1'b1, 1'b1);
    idle();
    read_word(50, v);
    chk_w("R6 deselected write ignored", v, pat(50, 4));
  endtask

  task automatic t_raw();
    wr_all(60, pat(60, 5));
    step(1'b1, 60, '0, '0, 1'b0, 1'b0);
    step(1'b0, 0, '0, '0, 1'b0, 1'b0);
    chk_w("R7 read after write", rdata, pat(60, 5));
  endtask

  task automatic t_desel_mode(input logic mode);
    dual_mode = mode;
    wr_all(70, pat(70, 6));
    idle();
    step(1'b1, 70, '0, '0, 1'b0, 1'b0);
    step(1'b1, 70, '0, '0, 1'b0, 1'b0);
    chk_b(mode ? "R9 first read driven" : "R8 first read driven", rdata_oe, 1'b1);
    idle();
    chk_w(mode ? "R9 data" : "R8 data", rdata, pat(70, 6));
    if (mode) chk_b("R9 held after deselect", rdata_oe, 1'b1);
    else      chk_b("R8 cut at deselect", rdata_oe, 1'b0);
    idle();
    chk_b(mode ? "R9 off second cycle" : "R8 off second cycle", rdata_oe, 1'b0);
    // single read then deselect
    step(1'b1, 70, '0, '0, 1'b0, 1'b0);
    idle();
    chk_b(mode ? "R9 lone read" : "R8 lone read", rdata_oe, mode);
    idle();
    dual_mode = 1'b1;
  endtask

  task automatic t_oe_async();
    step(1'b1, 70, '0, '0, 1'b0, 1'b0);
    step(1'b1, 70, '0, '0, 1'b0, 1'b0);
    #1 oe = 1'b0;
    #1 chk_b("R10 oe low", rdata_oe, 1'b0);
    oe = 1'b1;
    #1 chk_b("R10 oe high", rdata_oe, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_hold();
    logic [W-1:0] v;
    read_word(3, v);
    idle();
    wr_all(90, pat(90, 8));
    chk_w("R11 hold over write", rdata, v);
    idle();
    chk_w("R11 hold over idle", rdata, v);
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_global_and_read();
    t_byte_write();
    t_no_strobe();
    t_deselect_write();
    t_raw();
    t_desel_mode(1'b0);
    t_desel_mode(1'b1);
    t_oe_async();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule